// File: doc/BRIEF.md
# Priority Reference Selector with Revertivity

This block picks which of `N` candidate timing references drives one timing generator. Two modes exist. In manual mode the index supplied by software is taken as it is, whether or not that input is currently qualified. In automatic mode the block chooses among inputs that are both qualified and enabled. Each input has its own programmable priority, and a lower nonzero value ranks higher. A priority of zero takes the input out of the automatic choice.

A revertive control decides what happens when a better input becomes usable while the present choice is still good. When revertive, the better input takes over. When non-revertive, the present choice is kept for as long as it stays usable. If the present choice stops being usable, the block moves to the best usable input in either setting. If no input is usable, the block drops its valid flag and keeps the last index. Every change of the chosen index raises a one-cycle handover pulse, which a downstream phase-alignment stage can use.

A system with two timing generators places two instances side by side, each fed from its own priority table. The choice is registered, so the outputs reflect the inputs sampled at the previous rising clock edge. Internally a three-state machine tracks the selection. `SEL_NONE` means nothing is chosen. `SEL_MANUAL` means software owns the choice. `SEL_TRACK` means an automatic choice is held. The transitions are as follows:
- Any state goes to `SEL_MANUAL` while automatic mode is off.
- `SEL_NONE` goes to `SEL_TRACK` once some input is usable.
- `SEL_MANUAL` and `SEL_TRACK` go to `SEL_TRACK`, keeping or replacing the index, while some input is usable.
- `SEL_MANUAL` and `SEL_TRACK` go to `SEL_NONE` when no input is usable.

Top module: `ref_selector`

## Requirements
- R1: While reset is asserted, the selected index is 0, the valid flag is 0 and the handover pulse is 0.
- R2: With the automatic-mode input at 0, the next cycle shows the manual index with valid at 1, whatever the qualification flags hold.
- R3: In automatic mode, an input is usable when its qualification bit is 1 and its priority field is nonzero. When a new choice is made, it is the usable input with the lowest priority value.
- R4: When usable inputs share the lowest priority value, the one with the lowest index is chosen.
- R5: An input whose priority field is 0 is never chosen in automatic mode, even when qualified.
- R6: With the revertive input at 0, a current choice that stays usable is kept, even when a better input becomes usable.
- R7: With the revertive input at 1, a usable input whose priority value is strictly lower than the current choice's replaces it. An equal value does not replace it.
- R8: The handover pulse is 1 for exactly the cycle in which the selected index differs from its value in the previous cycle.
- R9: In automatic mode, when the current choice stops being usable and another input is usable, the best usable input is chosen, whatever the revertive setting.
- R10: In automatic mode with no usable input, valid goes to 0 and the selected index keeps its previous value.
- R11: The outputs change one clock edge after the inputs that cause the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| qual_i | input | N | One qualification flag per input, bit i for input i |
| prio_i | input | N*PW | Priority fields, field i at bits [i*PW +: PW]; 0 disables the input |
| auto_mode_i | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| revert_i | input | 1 | 1 allows a better usable input to take over |
| man_idx_i | input | IW | Index used in manual mode |
| sel_idx_o | output | IW | Selected input index |
| sel_valid_o | output | 1 | 1 when the selection is usable (always 1 in manual mode) |
| switch_o | output | 1 | One-cycle pulse on each change of the selected index |

## Verification
The hardest situation to reach is a current choice that is still usable while a strictly better input appears. That requires a prior sequence that first settled the choice on a worse input. The directed stimulus reaches it by qualifying only the worse input, waiting one cycle, and then qualifying the better one under each revertive setting. The equal-priority case is exercised the same way. After the directed part, a long random phase draws priorities from a small range so that ties are frequent, and it flips qualification, mode and revertivity. A behavioural model is compared with the outputs on every cycle.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_MANUAL = 2'd1,
        SEL_TRACK  = 2'd2
    } sel_state_e;
endpackage

// File: rtl/ref_elig.sv
// Marks each input usable when qualified and given a nonzero priority.
module ref_elig #(
    parameter int N  = 8,
    parameter int PW = 4
) (
    input  logic [N-1:0]    qual_i,
    input  logic [N*PW-1:0] prio_i,
    output logic [N-1:0]    elig_o
);
    for (genvar g = 0; g < N; g++) begin : g_in
        assign elig_o[g] = qual_i[g] && (prio_i[g*PW +: PW] != '0);
    end
endmodule

// File: rtl/ref_best.sv
// Finds the usable input with the lowest priority value; lowest index wins ties.
module ref_best #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]    elig_i,
    input  logic [N*PW-1:0] prio_i,
    output logic [IW-1:0]   best_idx_o,
    output logic [PW-1:0]   best_prio_o,
    output logic            found_o
);
    always_comb begin
        best_idx_o  = '0;
        best_prio_o = '1;
        found_o     = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (!found_o || (prio_i[i*PW +: PW] < best_prio_o))) begin
                best_idx_o  = IW'(i);
                best_prio_o = prio_i[i*PW +: PW];
                found_o     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_sel_fsm.sv
// Selection state machine: manual override, automatic tracking, revertivity.
module ref_sel_fsm
    import ref_sel_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            auto_mode_i,
    input  logic            revert_i,
    input  logic [IW-1:0]   man_idx_i,
    input  logic [N-1:0]    elig_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic [IW-1:0]   best_idx_i,
    input  logic [PW-1:0]   best_prio_i,
    input  logic            found_i,
    output logic [IW-1:0]   sel_idx_o,
    output logic            sel_valid_o,
    output logic            switch_o
);
    sel_state_e    state, nxt_state;
    logic [IW-1:0] nxt_idx;
    logic [PW-1:0] cur_prio;
    logic          cur_ok;
    logic          man_ok;

    assign cur_prio = prio_i[sel_idx_o*PW +: PW];
    assign cur_ok   = elig_i[sel_idx_o];
    assign man_ok   = (32'(man_idx_i) < N);

    // Next state and next index
    always_comb begin
        nxt_state = state;
        nxt_idx   = sel_idx_o;
        if (!auto_mode_i) begin
            nxt_state = SEL_MANUAL;
            if (man_ok) begin
                nxt_idx = man_idx_i;
            end
        end else begin
            unique case (state)
                SEL_NONE: begin
                    if (found_i) begin
                        nxt_state = SEL_TRACK;
                        nxt_idx   = best_idx_i;
                    end
                end
                SEL_MANUAL, SEL_TRACK: begin
                    if (!found_i) begin
                        nxt_state = SEL_NONE;
                    end else if (!cur_ok) begin
                        nxt_state = SEL_TRACK;
                        nxt_idx   = best_idx_i;
                    end else if (revert_i && (best_prio_i < cur_prio)) begin
                        nxt_state = SEL_TRACK;
                        nxt_idx   = best_idx_i;
                    end else begin
                        nxt_state = SEL_TRACK;
                    end
                end
                default: nxt_state = SEL_NONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEL_NONE;
        end else begin
            state <= nxt_state;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_idx_o   <= '0;
            sel_valid_o <= 1'b0;
            switch_o    <= 1'b0;
        end else begin
            sel_idx_o   <= nxt_idx;
            sel_valid_o <= (nxt_state != SEL_NONE);
            switch_o    <= (nxt_idx != sel_idx_o);
        end
    end
endmodule

// File: rtl/ref_selector.sv
module ref_selector #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    qual_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic            auto_mode_i,
    input  logic            revert_i,
    input  logic [IW-1:0]   man_idx_i,
    output logic [IW-1:0]   sel_idx_o,
    output logic            sel_valid_o,
    output logic            switch_o
);
    logic [N-1:0]  elig;
    logic [IW-1:0] best_idx;
    logic [PW-1:0] best_prio;
    logic          found;

    ref_elig #(.N(N), .PW(PW)) u_elig (
        .qual_i (qual_i),
        .prio_i (prio_i),
        .elig_o (elig)
    );

    ref_best #(.N(N), .PW(PW), .IW(IW)) u_best (
        .elig_i      (elig),
        .prio_i      (prio_i),
        .best_idx_o  (best_idx),
        .best_prio_o (best_prio),
        .found_o     (found)
    );

    ref_sel_fsm #(.N(N), .PW(PW), .IW(IW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_mode_i (auto_mode_i),
        .revert_i    (revert_i),
        .man_idx_i   (man_idx_i),
        .elig_i      (elig),
        .prio_i      (prio_i),
        .best_idx_i  (best_idx),
        .best_prio_i (best_prio),
        .found_i     (found),
        .sel_idx_o   (sel_idx_o),
        .sel_valid_o (sel_valid_o),
        .switch_o    (switch_o)
    );
endmodule

// File: rtl/ref_selector_chk.sv
module ref_selector_chk #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    qual_i,
    input logic [N*PW-1:0] prio_i,
    input logic            auto_mode_i,
    input logic            revert_i,
    input logic [IW-1:0]   man_idx_i,
    input logic [IW-1:0]   sel_idx_o,
    input logic            sel_valid_o,
    input logic            switch_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    function automatic logic usable(input logic [N-1:0] q, input logic [N*PW-1:0] p,
                                    input logic [IW-1:0] idx);
        return q[idx] && (p[idx*PW +: PW] != '0);
    endfunction

    function automatic logic any_usable(input logic [N-1:0] q, input logic [N*PW-1:0] p);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (q[i] && (p[i*PW +: PW] != '0)) r = 1'b1;
        end
        return r;
    endfunction

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(auto_mode_i) |-> sel_valid_o && (sel_idx_o == $past(man_idx_i))); // R2

    AST_CHOICE_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(auto_mode_i) && sel_valid_o |-> usable($past(qual_i), $past(prio_i), sel_idx_o)); // R3

    AST_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(auto_mode_i) && !any_usable($past(qual_i), $past(prio_i))
        |-> !sel_valid_o && (sel_idx_o == $past(sel_idx_o))); // R10

    AST_NONREV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(auto_mode_i && !revert_i && sel_valid_o && usable(qual_i, prio_i, sel_idx_o))
        |-> $stable(sel_idx_o)); // R6

    AST_SWITCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (switch_o == (sel_idx_o != $past(sel_idx_o)))); // R8

    AST_LOSS_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(auto_mode_i && sel_valid_o && !usable(qual_i, prio_i, sel_idx_o)
                       && any_usable(qual_i, prio_i))
        |-> (sel_idx_o != $past(sel_idx_o)) && sel_valid_o); // R9
endmodule

bind ref_selector ref_selector_chk #(.N(N), .PW(PW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .qual_i      (qual_i),
    .prio_i      (prio_i),
    .auto_mode_i (auto_mode_i),
    .revert_i    (revert_i),
    .man_idx_i   (man_idx_i),
    .sel_idx_o   (sel_idx_o),
    .sel_valid_o (sel_valid_o),
    .switch_o    (switch_o)
);

// File: tb/sim_ref_selector.sv
`timescale 1ns/1ps
module sim_ref_selector;
    localparam int N  = 8;
    localparam int PW = 4;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    qual = '0;
    logic [N*PW-1:0] prio = '0;
    logic            auto_m = 1'b0;
    logic            revert = 1'b0;
    logic [IW-1:0]   man_idx = '0;
    logic [IW-1:0]   sel_idx;
    logic            sel_valid;
    logic            sw;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    int m_idx = 0;
    int m_valid = 0;
    int m_sw = 0;

    always #5 clk = ~clk;

    ref_selector #(.N(N), .PW(PW), .IW(IW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual_i      (qual),
        .prio_i      (prio),
        .auto_mode_i (auto_m),
        .revert_i    (revert),
        .man_idx_i   (man_idx),
        .sel_idx_o   (sel_idx),
        .sel_valid_o (sel_valid),
        .switch_o    (sw)
    );

    function automatic int pr(int i);
        return int'(prio[i*PW +: PW]);
    endfunction

    function automatic bit ok(int i);
        return qual[i] && (pr(i) != 0);
    endfunction

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx = 0; m_valid = 0; m_sw = 0;
        end else begin
            int n, best, v;
            n = m_idx; v = m_valid; best = -1;
            for (int i = 0; i < N; i++)
                if (ok(i) && (best < 0 || pr(i) < pr(best))) best = i;
            if (!auto_m) begin
                n = int'(man_idx); v = 1;
            end else if (best < 0) begin
                v = 0;
            end else if (m_valid == 1 && ok(m_idx)) begin
                if (revert && pr(best) < pr(m_idx)) n = best;
                v = 1;
            end else begin
                n = best; v = 1;
            end
            m_sw = (n != m_idx);
            m_idx = n; m_valid = v;
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_tag, int'(sel_idx), m_idx, "model sel_idx");
            check(cur_tag, int'(sel_valid), m_valid, "model sel_valid");
            check(cur_tag, int'(sw), m_sw, "model switch");
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic setp(int i, int v);
        prio[i*PW +: PW] = PW'(v);
    endtask

    task automatic expect3(string tag, int idx, int v, int s);
        check(tag, int'(sel_idx), idx, "sel_idx");
        check(tag, int'(sel_valid), v, "sel_valid");
        check(tag, int'(sw), s, "switch");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        expect3("R1", 0, 0, 0);
        rst_n = 1'b1;
        tick();

        // Manual mode ignores qualification
        cur_tag = "R2";
        man_idx = 3'd5; qual = '0;
        tick();
        expect3("R2", 5, 1, 1);
        tick();
        expect3("R8", 5, 1, 0);
        man_idx = 3'd2;
        tick();
        expect3("R8", 2, 1, 1);

        // Automatic priority choice; input 2 has priority 0
        cur_tag = "R3";
        setp(3, 1); setp(6, 2); setp(1, 3);
        qual = '1; auto_m = 1'b1;
        tick();
        expect3("R3", 3, 1, 1);

        // Zero priority disables qualified inputs 0 and 2
        cur_tag = "R5";
        qual = 8'b0000_0111;
        tick();
        expect3("R5", 1, 1, 1);

        // Nothing usable: invalid, index held
        cur_tag = "R10";
        qual = 8'b0000_0101;
        tick();
        expect3("R10", 1, 0, 0);
        tick();
        expect3("R10", 1, 0, 0);

        // Tie on priority 3 between inputs 1 and 4
        cur_tag = "R4";
        setp(4, 3); qual = 8'b0000_1000 << 1 | 8'b0000_0010;
        qual = 8'b0001_0010;
        tick();
        expect3("R4", 1, 1, 0);

        // Active input lost: move to best
        cur_tag = "R9";
        qual = 8'b0100_0000;
        tick();
        expect3("R9", 6, 1, 1);

        // Non-revertive keeps input 6 when input 3 comes back
        cur_tag = "R6";
        qual = 8'b0100_1000;
        tick();
        expect3("R6", 6, 1, 0);
        tick();
        expect3("R6", 6, 1, 0);

        // Revertive: equal priority does not preempt
        cur_tag = "R7";
        setp(4, 2); revert = 1'b1; qual = 8'b0101_0000;
        tick();
        expect3("R7", 6, 1, 0);
        qual = 8'b0101_1000;
        tick();
        expect3("R7", 3, 1, 1);

        // Back to manual with an unqualified index; one-edge latency
        cur_tag = "R11";
        auto_m = 1'b0; man_idx = 3'd7; qual = '0;
        check("R11", int'(sel_idx), 3, "sel_idx before edge");
        tick();
        expect3("R11", 7, 1, 1);

        // Random phase
        cur_tag = "R3/R6/R7/R9";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 3) == 0) qual = N'($urandom);
            if ($urandom_range(0, 9) == 0)
                for (int i = 0; i < N; i++) setp(i, $urandom_range(0, 3));
            if ($urandom_range(0, 19) == 0) auto_m = ~auto_m;
            if ($urandom_range(0, 19) == 0) revert = ~revert;
            if ($urandom_range(0, 7) == 0) man_idx = IW'($urandom);
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule